// File: doc/BRIEF.md
# ACPI Sleep-State Power Sequencer

This block is the digital control core of a motherboard standby-power controller. It receives the two active-low sleep requests from the system chipset. Each request passes through a two-flop synchroniser and then a deglitch counter, so a level is accepted only after it has held steady for a parameterised number of clocks. The filtered requests drive a three-state tracker: active (S0/S1/S2), suspend-to-RAM (S3) and soft-off (S4/S5). The tracker refuses a direct move from soft-off into suspend.

The tracked state is decoded into one enable per power path:

- the 3.3 V dual rail, through either the bypass switch or the standby regulator;
- the 5 V dual rail, through either the main NMOS switch or the standby PMOS switch;
- the 1.2 V VID regulator;
- the auxiliary LAN regulator.

Two board straps change that mapping. One keeps the 5 V dual rail alive in soft-off. The other keeps the LAN regulator powered in every state.

Undervoltage flags, two supply-input monitor flags and an overtemperature flag from external comparators are merged into a single fault output. A flag that belongs to a rail which is currently off is masked. An external shutdown input, which stands for the soft-start node being pulled to ground, turns off every enable and holds the fault output low.

All pins are plain control and status levels. The block has no streaming interface, so no valid/ready handshake or back-pressure applies.

Top module: `acpi_pwr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to soft-off. It stays there after release until a filtered request moves it. In soft-off, `state`=2 and `en_3v3_ldo`=1. `en_5v_stby` equals `strap_keep5`, `en_vout1` equals `strap_lan_always`, and all other enables are 0.
- R2: A sleep-input level is accepted only after it has been present for FILT_CYCLES consecutive synchronised samples. A level change driven just after a rising edge first shows on `state` after the (FILT_CYCLES+3)-th rising edge that follows. A pulse shorter than FILT_CYCLES clocks has no effect on `state`.
- R3: The filtered requests decode as follows:
  - `slp_s5_n` low requests soft-off, whatever `slp_s3_n` is.
  - `slp_s3_n` low with `slp_s5_n` high requests suspend.
  - Both high request active.
  - The `state` codes are 0 = active, 1 = suspend, 2 = soft-off.
- R4: A suspend request while in soft-off leaves `state` at 2 until an active request arrives. Moving from suspend to soft-off is allowed.
- R5: `en_3v3_bypass` is 1 only in active. `en_3v3_ldo` is 1 only in suspend and soft-off, so exactly one of the two is high whenever shutdown is low.
- R6: `en_5v_main` is 1 only in active. `en_5v_stby` is 1 in suspend, and in soft-off only when `strap_keep5` is 1.
- R7: `en_vid` is 1 only in active.
- R8: `en_vout1` is 1 in every state when `strap_lan_always` is 1. When the strap is 0, it is 1 only in active.
- R9: `fault` is 1 when `overtemp` is set or when any unmasked flag is set. The flag bits are:
  - `uv_rail[0]` = 3.3 V dual rail
  - `uv_rail[1]` = 5 V dual rail
  - `uv_rail[2]` = VID rail
  - `uv_rail[3]` = LAN rail
  - `uv_atx[0]` = 3.3 V input
  - `uv_atx[1]` = 5 V input

  Otherwise `fault` is 0. `fault` responds combinationally in the same cycle.
- R10: A `uv_rail` bit is masked while its rail is unpowered. Both `uv_atx` bits are masked outside active.
- R11: While `shutdown` is 1, every enable and `fault` is 0, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| slp_s3_n | input | 1 | Suspend request, active low, asynchronous |
| slp_s5_n | input | 1 | Soft-off request, active low, asynchronous |
| strap_keep5 | input | 1 | Strap: keep 5 V dual rail on in soft-off |
| strap_lan_always | input | 1 | Strap: LAN regulator on in every state |
| shutdown | input | 1 | External shutdown, active high |
| uv_rail | input | 4 | Undervoltage flags of the controlled rails |
| uv_atx | input | 2 | Undervoltage flags of the 3.3 V and 5 V inputs |
| overtemp | input | 1 | Overtemperature flag |
| state | output | 2 | Tracked power state (0 active, 1 suspend, 2 soft-off) |
| en_3v3_bypass | output | 1 | 3.3 V dual rail: bypass switch enable |
| en_3v3_ldo | output | 1 | 3.3 V dual rail: standby regulator enable |
| en_5v_main | output | 1 | 5 V dual rail: main NMOS switch enable |
| en_5v_stby | output | 1 | 5 V dual rail: standby PMOS switch enable |
| en_vid | output | 1 | 1.2 V VID regulator enable |
| en_vout1 | output | 1 | LAN regulator enable |
| fault | output | 1 | Merged fault output |

## Verification
A sleep-input change reaches `state` FILT_CYCLES+3 rising edges after it is driven: two synchroniser stages, FILT_CYCLES counting edges ending in the filter update, then the state register. The enables follow `state` with no extra delay, while `fault` and the shutdown gating follow their inputs in the same cycle. The bench drives inputs one time unit after a rising edge and samples on the falling edge. Its behavioural model advances on every rising edge and is compared with all outputs on every falling edge. Directed checks sample once on the edge before the expected `state` change and once on the edge after it, to pin the latency exactly.

// File: rtl/acpi_seq_pkg.sv
package acpi_seq_pkg;
  typedef enum logic [1:0] {
    PS_ACTIVE  = 2'd0,
    PS_SUSPEND = 2'd1,
    PS_SOFTOFF = 2'd2
  } pstate_e;

  localparam int N_RAIL   = 4;
  localparam int N_ATX    = 2;
  localparam int RAIL_3V3 = 0;
  localparam int RAIL_5V  = 1;
  localparam int RAIL_VID = 2;
  localparam int RAIL_LAN = 3;

  typedef struct packed {
    logic sw3v3;
    logic ldo3v3;
    logic nsw5v;
    logic psw5v;
    logic vid;
    logic vout1;
  } rail_en_t;
endpackage

// File: rtl/sync_deglitch.sv
module sync_deglitch #(
  parameter int   STAGES      = 2,
  parameter int   FILT_CYCLES = 50,
  parameter logic RST_VAL     = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYCLES - 1);

  logic [STAGES-1:0] sh;
  logic [CW-1:0]     cnt;
  logic              sampled;

  assign sampled = sh[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) sh <= {STAGES{RST_VAL}};
    else     sh <= {sh[STAGES-2:0], din};
  end

  // A new level must persist for FILT_CYCLES samples before it is taken.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      dout <= RST_VAL;
    end else if (sampled == dout) begin
      cnt <= '0;
    end else if (cnt == CNT_LAST) begin
      cnt  <= '0;
      dout <= sampled;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pstate_fsm.sv
module pstate_fsm
  import acpi_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    s3_filt_n,
  input  logic    s5_filt_n,
  output pstate_e cur
);
  pstate_e nxt;

  always_comb begin
    nxt = cur;
    if (!s5_filt_n) begin
      nxt = PS_SOFTOFF;
    end else if (!s3_filt_n) begin
      // Soft-off may not fall straight into suspend.
      if (cur != PS_SOFTOFF) nxt = PS_SUSPEND;
    end else begin
      nxt = PS_ACTIVE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= PS_SOFTOFF;
    else     cur <= nxt;
  end
endmodule

// File: rtl/rail_decode.sv
module rail_decode
  import acpi_seq_pkg::*;
(
  input  pstate_e             cur,
  input  logic                keep5,
  input  logic                lan_always,
  input  logic                shutdown,
  input  logic [N_RAIL-1:0]   uv_rail,
  input  logic [N_ATX-1:0]    uv_atx,
  input  logic                overtemp,
  output rail_en_t            en,
  output logic                fault
);
  rail_en_t          raw;
  logic              in_act;
  logic              in_sleep;
  logic [N_RAIL-1:0] rail_on;
  logic              any_flag;

  assign in_act   = (cur == PS_ACTIVE);
  assign in_sleep = !in_act;

  always_comb begin
    raw.sw3v3  = in_act;
    raw.ldo3v3 = in_sleep;
    raw.nsw5v  = in_act;
    raw.psw5v  = (cur == PS_SUSPEND) || ((cur == PS_SOFTOFF) && keep5);
    raw.vid    = in_act;
    raw.vout1  = in_act || lan_always;
  end

  always_comb begin
    rail_on           = '0;
    rail_on[RAIL_3V3] = 1'b1;
    rail_on[RAIL_5V]  = raw.nsw5v || raw.psw5v;
    rail_on[RAIL_VID] = raw.vid;
    rail_on[RAIL_LAN] = raw.vout1;
  end

  assign any_flag = overtemp || (|(uv_rail & rail_on)) || (in_act && (|uv_atx));
  assign en       = shutdown ? '0 : raw;
  assign fault    = !shutdown && any_flag;
endmodule

// File: rtl/acpi_pwr_seq.sv
module acpi_pwr_seq
  import acpi_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       slp_s3_n,
  input  logic       slp_s5_n,
  input  logic       strap_keep5,
  input  logic       strap_lan_always,
  input  logic       shutdown,
  input  logic [3:0] uv_rail,
  input  logic [1:0] uv_atx,
  input  logic       overtemp,
  output logic [1:0] state,
  output logic       en_3v3_bypass,
  output logic       en_3v3_ldo,
  output logic       en_5v_main,
  output logic       en_5v_stby,
  output logic       en_vid,
  output logic       en_vout1,
  output logic       fault
);
  localparam int N_REQ = 2;

  logic [N_REQ-1:0] req_raw;
  logic [N_REQ-1:0] req_filt;
  pstate_e          cur;
  rail_en_t         en;

  assign req_raw = {slp_s5_n, slp_s3_n};

  for (genvar i = 0; i < N_REQ; i++) begin : g_req
    sync_deglitch #(
      .STAGES     (SYNC_STAGES),
      .FILT_CYCLES(FILT_CYCLES),
      .RST_VAL    (1'b0)
    ) u_dg (
      .clk (clk),
      .rst (rst),
      .din (req_raw[i]),
      .dout(req_filt[i])
    );
  end

  pstate_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .s3_filt_n(req_filt[0]),
    .s5_filt_n(req_filt[1]),
    .cur      (cur)
  );

  rail_decode u_dec (
    .cur       (cur),
    .keep5     (strap_keep5),
    .lan_always(strap_lan_always),
    .shutdown  (shutdown),
    .uv_rail   (uv_rail),
    .uv_atx    (uv_atx),
    .overtemp  (overtemp),
    .en        (en),
    .fault     (fault)
  );

  assign state         = cur;
  assign en_3v3_bypass = en.sw3v3;
  assign en_3v3_ldo    = en.ldo3v3;
  assign en_5v_main    = en.nsw5v;
  assign en_5v_stby    = en.psw5v;
  assign en_vid        = en.vid;
  assign en_vout1      = en.vout1;
endmodule

// File: rtl/acpi_seq_chk.sv
module acpi_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       slp_s3_n,
  input logic       slp_s5_n,
  input logic       strap_keep5,
  input logic       strap_lan_always,
  input logic       shutdown,
  input logic [3:0] uv_rail,
  input logic [1:0] uv_atx,
  input logic       overtemp,
  input logic [1:0] state,
  input logic       en_3v3_bypass,
  input logic       en_3v3_ldo,
  input logic       en_5v_main,
  input logic       en_5v_stby,
  input logic       en_vid,
  input logic       en_vout1,
  input logic       fault
);
  AST_NO_SOFTOFF_TO_SUSPEND: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd2) |=> (state != 2'd1)); // R4

  AST_3V3_ONE_PATH: assert property (@(posedge clk) disable iff (rst)
    !shutdown |-> ($countones({en_3v3_bypass, en_3v3_ldo}) == 1)); // R5

  AST_5V_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({en_5v_main, en_5v_stby})); // R6

  AST_VID_ACTIVE_ONLY: assert property (@(posedge clk) disable iff (rst)
    en_vid |-> (state == 2'd0)); // R7

  AST_LAN_ALWAYS_ON: assert property (@(posedge clk) disable iff (rst)
    (strap_lan_always && !shutdown) |-> en_vout1); // R8

  AST_OTP_FAULT: assert property (@(posedge clk) disable iff (rst)
    (overtemp && !shutdown) |-> fault); // R9

  AST_SHDN_QUIET: assert property (@(posedge clk) disable iff (rst)
    shutdown |-> !(fault || en_3v3_bypass || en_3v3_ldo || en_5v_main ||
                   en_5v_stby || en_vid || en_vout1)); // R11
endmodule

bind acpi_pwr_seq acpi_seq_chk u_chk (.*);

// File: tb/sim_acpi_pwr_seq.sv
module sim_acpi_pwr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int FILT       = 50;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slp_s3_n = 1'b0, slp_s5_n = 1'b0;
  logic       strap_keep5 = 1'b1, strap_lan_always = 1'b1;
  logic       shutdown = 1'b0, overtemp = 1'b0;
  logic [3:0] uv_rail = 4'd0;
  logic [1:0] uv_atx = 2'd0;
  logic [1:0] state;
  logic       en_3v3_bypass, en_3v3_ldo, en_5v_main, en_5v_stby, en_vid, en_vout1, fault;

  int total = 0;
  int bad   = 0;

  acpi_pwr_seq #(.FILT_CYCLES(FILT)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cmp(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: delay queues, hold counters, state number.
  bit q3[$] = {1'b0, 1'b0};
  bit q5[$] = {1'b0, 1'b0};
  int c3 = 0, c5 = 0, ms = 2;
  bit f3 = 1'b0, f5 = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      q3 = {1'b0, 1'b0}; q5 = {1'b0, 1'b0};
      c3 = 0; c5 = 0; f3 = 1'b0; f5 = 1'b0; ms = 2;
    end else begin
      if (!f5) ms = 2;
      else if (!f3) begin if (ms != 2) ms = 1; end
      else ms = 0;
      if (q3[0] == f3) c3 = 0;
      else if (c3 == FILT-1) begin f3 = q3[0]; c3 = 0; end
      else c3++;
      if (q5[0] == f5) c5 = 0;
      else if (c5 == FILT-1) begin f5 = q5[0]; c5 = 0; end
      else c5++;
      q3.push_back(slp_s3_n); void'(q3.pop_front());
      q5.push_back(slp_s5_n); void'(q5.pop_front());
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      bit act, five_on, lan_on, ef;
      act     = (ms == 0);
      five_on = act || ms == 1 || (ms == 2 && strap_keep5);
      lan_on  = act || strap_lan_always;
      ef = overtemp || uv_rail[0] || (uv_rail[1] && five_on) || (uv_rail[2] && act) ||
           (uv_rail[3] && lan_on) || (act && (|uv_atx));
      cmp("R3 model state", state, ms);
      cmp("R5 model en_3v3_bypass", en_3v3_bypass, !shutdown && act);
      cmp("R5 model en_3v3_ldo", en_3v3_ldo, !shutdown && !act);
      cmp("R6 model en_5v_main", en_5v_main, !shutdown && act);
      cmp("R6 model en_5v_stby", en_5v_stby, !shutdown && !act && five_on);
      cmp("R7 model en_vid", en_vid, !shutdown && act);
      cmp("R8 model en_vout1", en_vout1, !shutdown && lan_on);
      cmp("R9 model fault", fault, !shutdown && ef);
    end
  end

  task automatic drive(input bit s3, input bit s5);
    @(posedge clk); #1;
    slp_s3_n = s3; slp_s5_n = s5;
  endtask

  task automatic settle();
    repeat (FILT + 5) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic flags(input logic [3:0] r, input logic [1:0] a, input bit o, input bit s);
    @(posedge clk); #1;
    uv_rail = r; uv_atx = a; overtemp = o; shutdown = s;
    @(negedge clk);
  endtask

  task automatic do_reset(input bit k5, input bit lan);
    @(posedge clk); #1;
    rst = 1'b1; strap_keep5 = k5; strap_lan_always = lan;
    slp_s3_n = 1'b0; slp_s5_n = 1'b0;
    repeat (3) @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    cmp("R1 reset state", state, 2);
    cmp("R1 reset en_3v3_ldo", en_3v3_ldo, 1);
    cmp("R1 reset en_5v_stby", en_5v_stby, 1);
    cmp("R1 reset en_vout1", en_vout1, 1);
    cmp("R1 reset en_vid", en_vid, 0);
    cmp("R1 reset en_3v3_bypass", en_3v3_bypass, 0);

    // R2 exact latency: soft-off to active
    drive(1, 1);
    repeat (FILT + 2) @(posedge clk);
    @(negedge clk);
    cmp("R2 state one edge early", state, 2);
    @(posedge clk); @(negedge clk);
    cmp("R2 state on time", state, 0);
    cmp("R5 active bypass", en_3v3_bypass, 1);
    cmp("R7 active vid", en_vid, 1);

    // R2 short pulse on soft-off request is ignored
    drive(1, 0);
    repeat (FILT - 2) @(posedge clk); #1;
    slp_s5_n = 1'b1;
    repeat (FILT + 10) @(posedge clk);
    @(negedge clk);
    cmp("R2 glitch ignored", state, 0);

    // Suspend entry
    drive(0, 1); settle();
    cmp("R3 suspend state", state, 1);
    cmp("R5 suspend ldo", en_3v3_ldo, 1);
    cmp("R6 suspend stby", en_5v_stby, 1);
    cmp("R7 suspend vid off", en_vid, 0);
    cmp("R8 suspend vout1 lan strap", en_vout1, 1);

    // R4 suspend to soft-off allowed, soft-off to suspend blocked
    drive(0, 0); settle();
    cmp("R4 suspend to softoff", state, 2);
    drive(0, 1); settle();
    cmp("R4 softoff to suspend blocked", state, 2);
    drive(1, 1); settle();
    cmp("R4 blocked then active", state, 0);
    drive(0, 1); settle();
    cmp("R4 active to suspend", state, 1);
    drive(1, 1); settle();

    // R9 fault merging in active
    flags(4'b0100, 2'b00, 0, 0); cmp("R9 vid uv in active", fault, 1);
    flags(4'b0000, 2'b10, 0, 0); cmp("R9 atx 5v uv in active", fault, 1);
    flags(4'b0000, 2'b00, 0, 0); cmp("R9 no flag", fault, 0);
    flags(4'b0000, 2'b00, 1, 0); cmp("R9 overtemp", fault, 1);
    flags(4'b0000, 2'b00, 0, 0);

    // R10 masking in soft-off (keep5=1, lan=1)
    drive(0, 0); settle();
    flags(4'b0100, 2'b00, 0, 0); cmp("R10 vid uv masked", fault, 0);
    flags(4'b0000, 2'b11, 0, 0); cmp("R10 atx uv masked", fault, 0);
    flags(4'b0010, 2'b00, 0, 0); cmp("R9 5v dual uv live", fault, 1);

    // R11 shutdown
    flags(4'b1111, 2'b11, 1, 1);
    cmp("R11 fault forced low", fault, 0);
    cmp("R11 enables off", {en_3v3_bypass, en_3v3_ldo, en_5v_main, en_5v_stby, en_vid, en_vout1}, 0);
    flags(4'b0000, 2'b00, 0, 0);
    cmp("R11 release ldo back", en_3v3_ldo, 1);

    // Straps low
    do_reset(0, 0);
    cmp("R1 reset straps low stby", en_5v_stby, 0);
    cmp("R1 reset straps low vout1", en_vout1, 0);
    flags(4'b1010, 2'b00, 0, 0); cmp("R10 off rails masked", fault, 0);
    flags(4'b0001, 2'b00, 0, 0); cmp("R9 3v3 dual uv live", fault, 1);
    flags(4'b0000, 2'b00, 0, 0);
    drive(1, 1); settle();
    cmp("R8 gigabit active vout1", en_vout1, 1);
    drive(0, 1); settle();
    cmp("R8 gigabit suspend vout1", en_vout1, 0);
    cmp("R6 suspend stby strap low", en_5v_stby, 1);
    drive(0, 0); settle();
    cmp("R6 softoff stby strap low", en_5v_stby, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule